// File: doc/BRIEF.md
# Tracker Queue Occupancy Monitor

This block sits beside a request tracker queue that has a fixed number of entries. It sees only the tracker's allocate and deallocate strobes, and from them it keeps a live count of the valid entries. Every clock it updates four statistics from that count:

- the cycles in which every entry was taken;
- the cycles in which at least one entry was valid;
- a running sum of the occupancy;
- the number of allocations that were accepted.

Software reads the four accumulators. Dividing the occupancy sum by the allocation count gives the mean time an entry stays between its allocate and its deallocate.

Each statistic samples the occupancy registered at the start of the cycle, which is the value shown on `occupancy_o`. An entry allocated in cycle t and released in cycle t+L therefore adds exactly L to the sum.

Strobes that cannot be honoured are rejected and leave a sticky error. An allocate alone on a full queue and a deallocate alone on an empty queue are both rejected this way. A synchronous clear restarts the measurement window and leaves the live occupancy alone. The accumulators are 48 bits wide by default, and they stop at all-ones instead of wrapping.

Top module: `tracker_occ_mon`

## Requirements
- R1: An allocate strobe alone on a non-full queue raises `occupancy_o` by one at the next clock edge. A deallocate strobe alone on a non-empty queue lowers it by one. `occupancy_o` never exceeds ENTRIES.
- R2: When allocate and deallocate are both high in one cycle, the occupancy is unchanged and the allocation is counted. No error is raised, even if the queue is empty or full.
- R3: `full_cycles_o` grows by one for every cycle in which `occupancy_o` equals ENTRIES.
- R4: `busy_cycles_o` grows by one for every cycle in which `occupancy_o` is non-zero.
- R5: `occ_sum_o` grows by the value of `occupancy_o` every cycle. A lone entry allocated in cycle t and deallocated in cycle t+L adds exactly L, so the sum divided by the allocation count is the mean residency.
- R6: `alloc_count_o` grows by one for each accepted allocation. Accepted allocations are those made alone on a non-full queue, plus every same-cycle allocate and deallocate pair.
- R7: An allocate alone on a full queue sets `error_o`. The occupancy is unchanged and the allocation is not counted.
- R8: A deallocate alone on an empty queue sets `error_o`, and the occupancy stays zero.
- R9: `error_o` stays high until reset. `clear_i` does not lower it.
- R10: `clear_i` makes all four accumulators zero at the next edge, and the events of the clear cycle are not counted. The occupancy keeps following the strobes.
- R11: Each accumulator stops at 2^ACC_W-1 and never wraps.
- R12: After reset, the occupancy, the four accumulators and `error_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_i | input | 1 | One tracker entry allocated this cycle |
| dealloc_i | input | 1 | One tracker entry released this cycle |
| clear_i | input | 1 | Zero the accumulators (synchronous) |
| occupancy_o | output | $clog2(ENTRIES+1) | Live count of valid entries |
| full_cycles_o | output | ACC_W | Cycles with every entry taken |
| busy_cycles_o | output | ACC_W | Cycles with at least one valid entry |
| occ_sum_o | output | ACC_W | Per-cycle sum of occupancy |
| alloc_count_o | output | ACC_W | Accepted allocations |
| error_o | output | 1 | Sticky flag for a rejected strobe |

## Verification
Allocate and deallocate can fall in the same cycle. The bench provokes this on a partly filled queue, on a full queue and on an empty queue. In each case it expects the occupancy to hold, the allocation count to rise by one and no error to appear. A clear can also coincide with such a pair. The bench judges that case by expecting zeroed accumulators the next cycle while the occupancy keeps its value.

// File: rtl/tom_pkg.sv
package tom_pkg;

    typedef enum logic [1:0] {
        EV_IDLE  = 2'd0,
        EV_ALLOC = 2'd1,
        EV_FREE  = 2'd2,
        EV_SWAP  = 2'd3
    } ev_e;

    function automatic ev_e classify(input logic alloc, input logic dealloc);
        return ev_e'({dealloc, alloc});
    endfunction

endpackage

// File: rtl/tom_occ_core.sv
module tom_occ_core #(
    parameter int ENTRIES = 8,
    parameter int CNT_W   = $clog2(ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_i,
    input  logic             dealloc_i,
    output logic [CNT_W-1:0] occ_o,
    output logic             take_o,
    output logic             err_o
);
    import tom_pkg::*;

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ENTRIES);

    typedef struct packed {
        logic [CNT_W-1:0] occ;
        logic             err;
    } core_t;

    core_t state_d, state_q;
    logic  take_d;

    always_comb begin
        state_d = state_q;
        take_d  = 1'b0;
        unique case (classify(alloc_i, dealloc_i))
            EV_ALLOC: begin
                if (state_q.occ == LIMIT) begin
                    state_d.err = 1'b1;
                end else begin
                    state_d.occ = state_q.occ + CNT_W'(1);
                    take_d      = 1'b1;
                end
            end
            EV_FREE: begin
                if (state_q.occ == '0) begin
                    state_d.err = 1'b1;
                end else begin
                    state_d.occ = state_q.occ - CNT_W'(1);
                end
            end
            EV_SWAP: take_d = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign occ_o  = state_q.occ;
    assign err_o  = state_q.err;
    assign take_o = take_d;

endmodule

// File: rtl/tom_sat_acc.sv
module tom_sat_acc #(
    parameter int ACC_W = 48,
    parameter int INC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [INC_W-1:0] inc_i,
    output logic [ACC_W-1:0] val_o
);
    localparam int SUM_W = ACC_W + 1;

    logic [ACC_W-1:0] val_d, val_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = {1'b0, val_q} + SUM_W'(inc_i);
        if (clr_i) begin
            val_d = '0;
        end else if (sum[ACC_W]) begin
            val_d = '1;
        end else begin
            val_d = sum[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign val_o = val_q;

endmodule

// File: rtl/tracker_occ_mon.sv
module tracker_occ_mon #(
    parameter int ENTRIES = 8,
    parameter int ACC_W   = 48,
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_i,
    input  logic             dealloc_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] occupancy_o,
    output logic [ACC_W-1:0] full_cycles_o,
    output logic [ACC_W-1:0] busy_cycles_o,
    output logic [ACC_W-1:0] occ_sum_o,
    output logic [ACC_W-1:0] alloc_count_o,
    output logic             error_o
);
    localparam int N_ACC = 4;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ENTRIES);

    logic [CNT_W-1:0] occ;
    logic             take;
    logic [CNT_W-1:0] inc [N_ACC];
    logic [ACC_W-1:0] acc [N_ACC];

    tom_occ_core #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_i   (alloc_i),
        .dealloc_i (dealloc_i),
        .occ_o     (occ),
        .take_o    (take),
        .err_o     (error_o)
    );

    // Per-cycle increments, all taken from the registered occupancy.
    always_comb begin
        inc[0] = CNT_W'(occ == LIMIT);
        inc[1] = CNT_W'(occ != '0);
        inc[2] = occ;
        inc[3] = CNT_W'(take);
    end

    for (genvar g = 0; g < N_ACC; g++) begin : g_acc
        tom_sat_acc #(.ACC_W(ACC_W), .INC_W(CNT_W)) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clear_i),
            .inc_i (inc[g]),
            .val_o (acc[g])
        );
    end

    assign occupancy_o   = occ;
    assign full_cycles_o = acc[0];
    assign busy_cycles_o = acc[1];
    assign occ_sum_o     = acc[2];
    assign alloc_count_o = acc[3];

endmodule

// File: rtl/tom_checker.sv
module tom_checker #(
    parameter int ENTRIES = 8,
    parameter int ACC_W   = 48,
    parameter int CNT_W   = $clog2(ENTRIES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_i,
    input logic             dealloc_i,
    input logic             clear_i,
    input logic [CNT_W-1:0] occupancy_o,
    input logic [ACC_W-1:0] full_cycles_o,
    input logic [ACC_W-1:0] busy_cycles_o,
    input logic [ACC_W-1:0] occ_sum_o,
    input logic [ACC_W-1:0] alloc_count_o,
    input logic             error_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ENTRIES);

    a_r1_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy_o <= LIMIT);

    a_r1_grow: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && !dealloc_i && occupancy_o != LIMIT)
        |=> occupancy_o == $past(occupancy_o) + CNT_W'(1));

    a_r2_swap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && dealloc_i) |=> $stable(occupancy_o));

    a_r7_full_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && !dealloc_i && occupancy_o == LIMIT)
        |=> (error_o && occupancy_o == LIMIT));

    a_r8_empty_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (dealloc_i && !alloc_i && occupancy_o == '0)
        |=> (error_o && occupancy_o == '0));

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |=> error_o);

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (full_cycles_o == '0 && busy_cycles_o == '0
                     && occ_sum_o == '0 && alloc_count_o == '0));

    a_r11_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (occ_sum_o >= $past(occ_sum_o)
                      && busy_cycles_o >= $past(busy_cycles_o)));

endmodule

bind tracker_occ_mon tom_checker #(.ENTRIES(ENTRIES), .ACC_W(ACC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_i       (alloc_i),
    .dealloc_i     (dealloc_i),
    .clear_i       (clear_i),
    .occupancy_o   (occupancy_o),
    .full_cycles_o (full_cycles_o),
    .busy_cycles_o (busy_cycles_o),
    .occ_sum_o     (occ_sum_o),
    .alloc_count_o (alloc_count_o),
    .error_o       (error_o)
);

// File: tb/tracker_occ_mon_bench.sv
`timescale 1ns/1ps
module tracker_occ_mon_bench;
    localparam int E     = 4;
    localparam int AW    = 8;
    localparam int CW    = $clog2(E + 1);
    localparam int MAXV  = (1 << AW) - 1;
    localparam int NVEC  = 14;

    // {alloc, dealloc, expected occupancy after the step}
    localparam logic [4:0] VEC [NVEC] = '{
        {2'b10, 3'd1}, {2'b10, 3'd2}, {2'b11, 3'd2}, {2'b10, 3'd3},
        {2'b10, 3'd4}, {2'b00, 3'd4}, {2'b11, 3'd4}, {2'b01, 3'd3},
        {2'b01, 3'd2}, {2'b01, 3'd1}, {2'b01, 3'd0}, {2'b11, 3'd0},
        {2'b10, 3'd1}, {2'b00, 3'd1}
    };

    logic clk = 1'b0;
    logic rst_n, alloc, dealloc, clear;
    logic [CW-1:0] occ;
    logic [AW-1:0] full_c, busy_c, sum_c, alloc_c;
    logic err;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    int m_occ, m_full, m_busy, m_sum, m_alloc;
    bit m_err;

    always #2.5 clk = ~clk;

    tracker_occ_mon #(.ENTRIES(E), .ACC_W(AW)) u_tracker_occ_mon (
        .clk(clk), .rst_n(rst_n), .alloc_i(alloc), .dealloc_i(dealloc),
        .clear_i(clear), .occupancy_o(occ), .full_cycles_o(full_c),
        .busy_cycles_o(busy_c), .occ_sum_o(sum_c), .alloc_count_o(alloc_c),
        .error_o(err)
    );

    function automatic int sat(int v, int inc);
        return (v + inc > MAXV) ? MAXV : v + inc;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; alloc = 0; dealloc = 0; clear = 0;
        m_occ = 0; m_full = 0; m_busy = 0; m_sum = 0; m_alloc = 0; m_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Apply one cycle of stimulus; the model follows the requirements.
    task automatic step(bit a, bit d, bit c);
        bit taken;
        @(negedge clk);
        alloc = a; dealloc = d; clear = c;
        taken = a && (d || m_occ < E);
        if (c) begin
            m_full = 0; m_busy = 0; m_sum = 0; m_alloc = 0;
        end else begin
            m_full  = sat(m_full, (m_occ == E) ? 1 : 0);
            m_busy  = sat(m_busy, (m_occ != 0) ? 1 : 0);
            m_sum   = sat(m_sum, m_occ);
            m_alloc = sat(m_alloc, taken ? 1 : 0);
        end
        if (a && !d) begin
            if (m_occ == E) m_err = 1; else m_occ++;
        end else if (d && !a) begin
            if (m_occ == 0) m_err = 1; else m_occ--;
        end
        @(posedge clk);
        #1;
        alloc = 0; dealloc = 0; clear = 0;
    endtask

    task automatic chk_acc(string tag);
        chk({tag, " R3 full cycles"}, int'(full_c), m_full);
        chk({tag, " R4 busy cycles"}, int'(busy_c), m_busy);
        chk({tag, " R5 occupancy sum"}, int'(sum_c), m_sum);
        chk({tag, " R6 alloc count"}, int'(alloc_c), m_alloc);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        #1;
        // R12 reset state
        chk("R12 occupancy", int'(occ), 0);
        chk("R12 error", int'(err), 0);
        chk_acc("R12");

        // Table walk: R1 and R2 occupancy per step
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][4], VEC[i][3], 1'b0);
            chk($sformatf("R1/R2 vector %0d occupancy", i), int'(occ), int'(VEC[i][2:0]));
        end
        chk_acc("table");
        chk("R2 no error on swaps at full and empty", int'(err), 0);

        // R7 allocate alone on full queue
        repeat (3) step(1, 0, 0);
        chk("R1 filled", int'(occ), E);
        step(1, 0, 0);
        chk("R7 occupancy held", int'(occ), E);
        chk("R7 error set", int'(err), 1);
        chk("R7 not counted", int'(alloc_c), m_alloc);

        // R10 clear together with a swap; R9 error survives clear
        step(1, 1, 1);
        chk("R10 occupancy kept", int'(occ), E);
        chk_acc("R10 cleared");
        chk("R10 full zero", int'(full_c), 0);
        chk("R9 error survives clear", int'(err), 1);
        step(0, 0, 0);
        chk("R10 resume sum", int'(sum_c), E);

        // R5 latency: single entry held L cycles
        repeat (E) step(0, 1, 0);
        step(0, 0, 1);
        step(1, 0, 0);
        repeat (4) step(0, 0, 0);
        step(0, 1, 0);
        step(0, 0, 0);
        chk("R5 latency sum", int'(sum_c), 5);
        chk("R6 single alloc", int'(alloc_c), 1);
        chk("R5 average", int'(sum_c) / int'(alloc_c), 5);

        // R8 deallocate on empty, after a fresh reset
        do_reset();
        #1;
        chk("R12 error after reset", int'(err), 0);
        step(0, 1, 0);
        chk("R8 occupancy zero", int'(occ), 0);
        chk("R8 error set", int'(err), 1);

        // R11 saturation
        step(0, 0, 1);
        repeat (E) step(1, 0, 0);
        repeat (300) step(0, 0, 0);
        chk("R11 full saturated", int'(full_c), MAXV);
        chk("R11 busy saturated", int'(busy_c), MAXV);
        chk("R11 sum saturated", int'(sum_c), MAXV);
        chk("R11 alloc count", int'(alloc_c), E);
        chk_acc("R11 model");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule